// File: doc/BRIEF.md
# Chroma 8x8 DC Intra Predictor

This block builds the DC prediction for one 8x8 chroma block of 8-bit samples. Its inputs are the row of eight reconstructed samples just above the block and the column of eight just to its left. Two flags say which of these neighbour edges exist. The block is split into four 4x4 quadrants, and each quadrant gets its own flat DC level. The neighbours that feed each quadrant depend on where the quadrant sits and on which edges are present.

A one-cycle start pulse captures the neighbours and the flags. The block then streams the prediction out one row per cycle, top row first. Each row carries eight samples, and a strobe marks every row. The bottom row also carries an end marker. While a block is streaming, a busy flag stays high and any new start pulse is dropped. The neighbour inputs may change freely once the start pulse has been taken.

Top module: `chroma_dc_pred`

## Requirements
- R1: With both edges present, the top-left quadrant (rows 0-3, columns 0-3) equals (sum of above 0..3 + sum of left 0..3 + 4) >> 3. The bottom-right quadrant (rows 4-7, columns 4-7) equals the same formula over above 4..7 and left 4..7.
- R2: With both edges present, the top-right quadrant equals (sum of above 4..7 + 2) >> 2. The bottom-left quadrant equals (sum of left 4..7 + 2) >> 2.
- R3: With only the left edge present, every sample of rows 0-3 equals (sum of left 0..3 + 2) >> 2. Every sample of rows 4-7 equals (sum of left 4..7 + 2) >> 2.
- R4: With only the above edge present, every sample of columns 0-3 equals (sum of above 0..3 + 2) >> 2. Every sample of columns 4-7 equals (sum of above 4..7 + 2) >> 2. This holds in every row.
- R5: With neither edge present, every output sample equals 128.
- R6: A start pulse taken while idle produces exactly eight consecutive valid cycles, beginning the cycle after the pulse, with rows in order 0 to 7. The last-row marker is high only with row 7.
- R7: Neighbour samples and flags are captured with the accepted start pulse. Changes to them during the output have no effect on that block.
- R8: Busy is high from the cycle after an accepted start through row 7 and low afterwards. A start pulse that arrives while busy is ignored and yields no extra rows.
- R9: After reset, the valid, last-row and busy outputs are low.
- R10: Packing: sample x of an output row sits in bits [8x+7:8x]. Above neighbour x and left neighbour y sit in the same bit positions of their input buses. Sums of all-255 neighbours do not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse; taken only while idle |
| avail_above_i | input | 1 | Above edge present |
| avail_left_i | input | 1 | Left edge present |
| above_i | input | 64 | Eight above neighbours, index x at bits 8x+7:8x |
| left_i | input | 64 | Eight left neighbours, index y at bits 8y+7:8y |
| row_valid_o | output | 1 | A prediction row is on row_data_o |
| row_last_o | output | 1 | Current row is row 7 |
| row_data_o | output | 64 | Eight predicted samples of the current row |
| busy_o | output | 1 | Block output in progress |

## Verification
The assertions assume that start_i is a clean synchronous signal and that reset is held for at least one clock edge. The flat-output check assumes the flags seen on an accepted start are the flags used for that block. The bench changes inputs only at falling edges. It randomises neighbours and flags on every block, and it also pulses start and scrambles the neighbours partway through some blocks, so both the ignored-start path and the capture path are exercised.

// File: rtl/chroma_dc_pkg.sv
package chroma_dc_pkg;
   // Which neighbour edges exist: bit 1 = above, bit 0 = left
   typedef enum logic [1:0] {
      EDGE_NONE  = 2'b00,
      EDGE_LEFT  = 2'b01,
      EDGE_ABOVE = 2'b10,
      EDGE_BOTH  = 2'b11
   } edge_sel_e;

   // Quadrant index = {row half, column half}
   typedef enum logic [1:0] {
      QD_TL = 2'd0,
      QD_TR = 2'd1,
      QD_BL = 2'd2,
      QD_BR = 2'd3
   } quad_e;
endpackage

// File: rtl/dc_half_sum.sv
module dc_half_sum #(
   parameter int W   = 8,
   parameter int CNT = 4,
   localparam int SW = W + $clog2(CNT)
) (
   input  logic [CNT*W-1:0] smp_i,
   output logic [SW-1:0]    sum_o
);
   always_comb begin
      sum_o = '0;
      for (int i = 0; i < CNT; i++)
         sum_o = sum_o + SW'(smp_i[i*W +: W]);
   end
endmodule

// File: rtl/dc_quad_calc.sv
module dc_quad_calc
   import chroma_dc_pkg::*;
#(
   parameter int W = 8,
   parameter int N = 8
) (
   input  logic [N*W-1:0]    above_i,
   input  logic [N*W-1:0]    left_i,
   input  edge_sel_e         sel_i,
   output logic [3:0][W-1:0] dc_o
);
   localparam int HALF = N / 2;
   localparam int SH_H = $clog2(HALF);
   localparam int SH_F = SH_H + 1;
   localparam int HS   = W + SH_H;
   localparam int FS   = HS + 1;
   localparam logic [W-1:0] MID = W'(1) << (W - 1);
   localparam logic [HS:0]  RND_H = (HS+1)'(1) << (SH_H - 1);
   localparam logic [FS:0]  RND_F = (FS+1)'(1) << (SH_F - 1);

   logic [1:0][HS-1:0] sum_a, sum_l;

   for (genvar g = 0; g < 2; g++) begin : g_half
      dc_half_sum #(.W(W), .CNT(HALF)) u_sa (
         .smp_i(above_i[g*HALF*W +: HALF*W]), .sum_o(sum_a[g]));
      dc_half_sum #(.W(W), .CNT(HALF)) u_sl (
         .smp_i(left_i[g*HALF*W +: HALF*W]),  .sum_o(sum_l[g]));
   end

   function automatic logic [W-1:0] avg_half(input logic [HS-1:0] s);
      logic [HS:0] t;
      t = {1'b0, s} + RND_H;
      return t[SH_H +: W];
   endfunction

   function automatic logic [W-1:0] avg_full(input logic [HS-1:0] a,
                                             input logic [HS-1:0] b);
      logic [FS:0] t;
      t = (FS+1)'(a) + (FS+1)'(b) + RND_F;
      return t[SH_F +: W];
   endfunction

   always_comb begin
      unique case (sel_i)
         EDGE_BOTH: begin
            dc_o[QD_TL] = avg_full(sum_a[0], sum_l[0]);
            dc_o[QD_TR] = avg_half(sum_a[1]);
            dc_o[QD_BL] = avg_half(sum_l[1]);
            dc_o[QD_BR] = avg_full(sum_a[1], sum_l[1]);
         end
         EDGE_LEFT: begin
            dc_o[QD_TL] = avg_half(sum_l[0]);
            dc_o[QD_TR] = avg_half(sum_l[0]);
            dc_o[QD_BL] = avg_half(sum_l[1]);
            dc_o[QD_BR] = avg_half(sum_l[1]);
         end
         EDGE_ABOVE: begin
            dc_o[QD_TL] = avg_half(sum_a[0]);
            dc_o[QD_TR] = avg_half(sum_a[1]);
            dc_o[QD_BL] = avg_half(sum_a[0]);
            dc_o[QD_BR] = avg_half(sum_a[1]);
         end
         default: dc_o = {4{MID}};
      endcase
   end
endmodule

// File: rtl/dc_row_emit.sv
module dc_row_emit #(
   parameter int W = 8,
   parameter int N = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [3:0][W-1:0] dc_i,
   output logic              busy_o,
   output logic              last_o,
   output logic [N*W-1:0]    row_o
);
   localparam int HALF = N / 2;
   localparam int CW   = $clog2(N);

   logic [3:0][W-1:0] dc_q;
   logic [CW-1:0]     row_q;
   logic              busy_q;
   logic              row_lo;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         row_q  <= '0;
         dc_q   <= '0;
      end else if (!busy_q) begin
         if (load_i) begin
            busy_q <= 1'b1;
            row_q  <= '0;
            dc_q   <= dc_i;
         end
      end else begin
         row_q <= row_q + 1'b1;
         if (row_q == CW'(N - 1))
            busy_q <= 1'b0;
      end
   end

   assign row_lo = row_q[CW-1];
   assign busy_o = busy_q;
   assign last_o = busy_q && (row_q == CW'(N - 1));

   for (genvar c = 0; c < N; c++) begin : g_col
      localparam logic COL_HI = (c >= HALF);
      assign row_o[c*W +: W] = dc_q[{row_lo, COL_HI}];
   end
endmodule

// File: rtl/chroma_dc_pred.sv
module chroma_dc_pred
   import chroma_dc_pkg::*;
#(
   parameter int SAMPLE_W = 8,
   parameter int BLK_N    = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start_i,
   input  logic                  avail_above_i,
   input  logic                  avail_left_i,
   input  logic [BLK_N*SAMPLE_W-1:0] above_i,
   input  logic [BLK_N*SAMPLE_W-1:0] left_i,
   output logic                  row_valid_o,
   output logic                  row_last_o,
   output logic [BLK_N*SAMPLE_W-1:0] row_data_o,
   output logic                  busy_o
);
   if (BLK_N < 4 || (BLK_N & (BLK_N - 1)) != 0) begin : g_bad_n
      $error("chroma_dc_pred: BLK_N must be a power of two, at least 4");
   end
   if (SAMPLE_W < 2) begin : g_bad_w
      $error("chroma_dc_pred: SAMPLE_W must be at least 2");
   end

   edge_sel_e                  sel;
   logic [3:0][SAMPLE_W-1:0]   dc;
   logic                       busy;

   assign sel = edge_sel_e'({avail_above_i, avail_left_i});

   dc_quad_calc #(.W(SAMPLE_W), .N(BLK_N)) u_calc (
      .above_i(above_i), .left_i(left_i), .sel_i(sel), .dc_o(dc));

   dc_row_emit #(.W(SAMPLE_W), .N(BLK_N)) u_emit (
      .clk(clk), .rst_n(rst_n), .load_i(start_i), .dc_i(dc),
      .busy_o(busy), .last_o(row_last_o), .row_o(row_data_o));

   assign busy_o      = busy;
   assign row_valid_o = busy;
endmodule

// File: rtl/chroma_dc_pred_chk.sv
module chroma_dc_pred_chk #(
   parameter int SAMPLE_W = 8,
   parameter int BLK_N    = 8
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  start_i,
   input logic                  avail_above_i,
   input logic                  avail_left_i,
   input logic [BLK_N*SAMPLE_W-1:0] above_i,
   input logic [BLK_N*SAMPLE_W-1:0] left_i,
   input logic                  row_valid_o,
   input logic                  row_last_o,
   input logic [BLK_N*SAMPLE_W-1:0] row_data_o,
   input logic                  busy_o
);
   localparam int CW = $clog2(BLK_N);
   localparam logic [SAMPLE_W-1:0] MID = SAMPLE_W'(1) << (SAMPLE_W - 1);

   logic [CW-1:0] cnt;
   logic          cap_a, cap_l;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt   <= '0;
         cap_a <= 1'b0;
         cap_l <= 1'b0;
      end else begin
         if (row_valid_o) cnt <= row_last_o ? '0 : cnt + 1'b1;
         if (start_i && !busy_o) begin
            cap_a <= avail_above_i;
            cap_l <= avail_left_i;
         end
      end
   end

   AST_LAST_IN_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      row_last_o |-> row_valid_o); // R6
   AST_LAST_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
      row_valid_o |-> (row_last_o == (cnt == CW'(BLK_N - 1)))); // R6
   AST_START_BEGINS: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o) |=> (row_valid_o && cnt == '0)); // R6
   AST_STOP_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      row_last_o |=> !busy_o); // R8
   AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !row_last_o) |=> busy_o); // R8
   AST_HALF_ROWS_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
      (row_valid_o && cnt != '0 && cnt != CW'(BLK_N / 2))
         |-> (row_data_o == $past(row_data_o))); // R1
   AST_FLAT_WHEN_NONE: assert property (@(posedge clk) disable iff (!rst_n)
      (row_valid_o && !cap_a && !cap_l) |-> (row_data_o == {BLK_N{MID}})); // R5
endmodule

bind chroma_dc_pred chroma_dc_pred_chk #(.SAMPLE_W(SAMPLE_W), .BLK_N(BLK_N)) u_chk (.*);

// File: tb/tb_chroma_dc_pred.sv
module tb_chroma_dc_pred;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic        avail_above_i = 1'b0;
   logic        avail_left_i = 1'b0;
   logic [63:0] above_i = '0;
   logic [63:0] left_i = '0;
   logic        row_valid_o, row_last_o, busy_o;
   logic [63:0] row_data_o;

   int n_chk = 0;
   int n_err = 0;
   bit done = 0;

   logic [7:0] ea [8];
   logic [7:0] el [8];
   logic [7:0] sa [8];
   logic [7:0] sl [8];
   logic       sua, sul;

   always #(CLK_PERIOD/2) clk = ~clk;

   chroma_dc_pred dut (.*);

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic int sum4(input bit left, input int base);
      int s = 0;
      for (int i = 0; i < 4; i++) s += left ? int'(sl[base+i]) : int'(sa[base+i]);
      return s;
   endfunction

   function automatic logic [7:0] exp_smp(input int r, input int c);
      int a0 = sum4(0, 0), a1 = sum4(0, 4), l0 = sum4(1, 0), l1 = sum4(1, 4);
      if (sua && sul) begin
         if (r < 4 && c < 4) return 8'((a0 + l0 + 4) >> 3);
         if (r < 4)          return 8'((a1 + 2) >> 2);
         if (c < 4)          return 8'((l1 + 2) >> 2);
         return 8'((a1 + l1 + 4) >> 3);
      end
      if (sul) return 8'(r < 4 ? (l0 + 2) >> 2 : (l1 + 2) >> 2);
      if (sua) return 8'(c < 4 ? (a0 + 2) >> 2 : (a1 + 2) >> 2);
      return 8'd128;
   endfunction

   function automatic logic [63:0] exp_row(input int r);
      logic [63:0] v;
      for (int c = 0; c < 8; c++) v[c*8 +: 8] = exp_smp(r, c);
      return v;
   endfunction

   task automatic drive_inputs(input logic ua, input logic ul);
      for (int i = 0; i < 8; i++) begin
         above_i[i*8 +: 8] = ea[i];
         left_i[i*8 +: 8]  = el[i];
      end
      avail_above_i = ua;
      avail_left_i  = ul;
   endtask

   task automatic run_block(input logic ua, input logic ul, input bit disturb);
      string tag;
      for (int i = 0; i < 8; i++) begin sa[i] = ea[i]; sl[i] = el[i]; end
      sua = ua; sul = ul;
      tag = (ua && ul) ? "R1 R2" : ul ? "R3" : ua ? "R4" : "R5";
      drive_inputs(ua, ul);
      @(negedge clk) start_i = 1'b1;
      @(negedge clk) start_i = 1'b0;
      for (int r = 0; r < 8; r++) begin
         if (r > 0) @(negedge clk);
         chk(row_valid_o && busy_o, "R6 R8", $sformatf("valid/busy row %0d", r),
             {62'd0, row_valid_o, busy_o}, 64'd3);
         chk(row_last_o == (r == 7), "R6", $sformatf("last row %0d", r),
             64'(row_last_o), 64'(r == 7));
         chk(row_data_o == exp_row(r), disturb ? "R7" : tag,
             $sformatf("R10 data row %0d", r), row_data_o, exp_row(r));
         if (disturb && r == 0) begin
            for (int i = 0; i < 8; i++) begin
               ea[i] = 8'($urandom); el[i] = 8'($urandom);
            end
            drive_inputs(1'($urandom), 1'($urandom));
         end
         if (disturb && r == 3) start_i = 1'b1;
         if (disturb && r == 4) start_i = 1'b0;
      end
      @(negedge clk);
      chk(!row_valid_o && !busy_o, "R8", "idle after row 7",
          {62'd0, row_valid_o, busy_o}, 64'd0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd7411));
      repeat (3) @(negedge clk);
      chk(!row_valid_o && !row_last_o && !busy_o, "R9", "reset outputs",
          {61'd0, row_valid_o, row_last_o, busy_o}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!row_valid_o && !busy_o, "R9", "idle after reset",
          {62'd0, row_valid_o, busy_o}, 64'd0);

      // directed: zeros, saturating all-255, distinct ramp in every mode
      for (int m = 0; m < 4; m++) begin
         for (int p = 0; p < 3; p++) begin
            for (int i = 0; i < 8; i++) begin
               ea[i] = (p == 0) ? 8'd0 : (p == 1) ? 8'hFF : 8'(i * 29 + 3);
               el[i] = (p == 0) ? 8'd0 : (p == 1) ? 8'hFF : 8'(250 - i * 31);
            end
            run_block(m[1], m[0], 1'b0);
         end
      end
      // random blocks, some disturbed mid-stream
      for (int k = 0; k < 40; k++) begin
         for (int i = 0; i < 8; i++) begin
            ea[i] = 8'($urandom); el[i] = 8'($urandom);
         end
         run_block(1'($urandom), 1'($urandom), 1'($urandom));
      end

      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule